// File: doc/BRIEF.md
# Gated Serial Byte Transmitter

This block is the send half of an asynchronous serial port. A host writes bytes through a small register port into a 16-entry holding queue. A baud-tick generator divides the system clock by a programmable 16-bit value to give a tick at sixteen times the bit rate. A shifter takes bytes from the queue one at a time and sends each one on a single output line as a framed character.

A host-owned enable flag controls only the hand-over of a byte from the queue to the shifter. When the host clears the flag, any frame already in flight finishes intact, and the line then stays idle. Bytes still in the queue wait there until the host sets the flag again. Software flow control, such as acting on received pause and resume characters, is left to the host. It stops and restarts output through this flag.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1, `tx_idle` is 1 and `overflow` is 0. Register 3 reads 0x80, which means the enable flag is set. Registers 1 and 2 read the default divisor bytes, low byte 0x01 and high byte 0x00.
- R2: There are four registers, selected by a 2-bit address. Address 0 pushes a byte into the queue and reads back 0x00. Address 1 holds the divisor low byte and address 2 the divisor high byte; both read back as written. Address 3 holds the enable flag in bit 7. Bits 6:0 of address 3 ignore writes and read as 0.
- R3: Each character is sent as one start bit (0), then 8 data bits with the LSB first, then one stop bit (1). The line idles at 1. Every bit lasts 16 baud ticks, and a baud tick occurs once every D clocks, where D is the divisor.
- R4: Bytes leave the line in the order they were written.
- R5: While the enable flag is 0, no new character starts. Queued bytes stay in the queue, so `fifo_empty` stays 0 and `txd` stays 1.
- R6: If the enable flag is cleared while a character is being sent, that character completes in full, including its stop bit.
- R7: When the flag is set while the shifter is idle and the queue holds data, the start bit appears within D+1 clocks of the write.
- R8: The queue holds 16 bytes. A push to a full queue is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R9: A divisor of 0 behaves like a divisor of 1, which gives 16 clocks per bit.
- R10: `fifo_empty` is 1 exactly when the queue holds no bytes. `tx_idle` is 1 when the queue is empty and no character is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| txd | output | 1 | Serial output line |
| fifo_empty | output | 1 | Queue holds no bytes |
| tx_idle | output | 1 | Queue empty and shifter not busy |
| overflow | output | 1 | Sticky flag for a push that was dropped |

## Verification
Faults in the shifter's bit or tick counters change the character that a line decoder sampling at mid-bit sees. They show up within one frame as a corrupted byte or a bad stop bit. A queue pointer fault shows up as bytes out of order, repeated or missing when the queue drains. A fault in the enable gate shows up either as a start bit while the flag is clear, or as a start bit that is late after the flag is set again. The decoder also measures bit timing, so a divisor fault, including the zero-divisor case, breaks the first frame sent at that rate.

// File: rtl/uart_txg_pkg.sv
// Package: shared constants for the gated serial transmitter.
// Assumes: a 2-bit register address and a fixed 10-bit character frame.
package uart_txg_pkg;
    localparam logic [1:0] ADDR_DATA   = 2'd0;
    localparam logic [1:0] ADDR_DIV_LO = 2'd1;
    localparam logic [1:0] ADDR_DIV_HI = 2'd2;
    localparam logic [1:0] ADDR_CTRL   = 2'd3;
    localparam int         EN_BIT      = 7;
    localparam int         FRAME_LEN   = 10;
    localparam int         OVERSAMPLE  = 16;
endpackage

// File: rtl/uart_txg_baud.sv
// Baud tick generator: issues a one-clock tick every max(div,1) clocks.
// Assumes: div may change at any time; the counter wraps as soon as it
// reaches or passes the new terminal value.
module uart_txg_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    // Treat a zero divisor as one so the tick never stops.
    always_comb div_eff = (div == '0) ? DIV_W'(1) : div;

    always_comb tick = (cnt >= div_eff - DIV_W'(1));

    // Count clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end

    // R3: with a divisor above one, ticks never fall on adjacent clocks.
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_eff > DIV_W'(1)) |=> (!tick || div_eff == DIV_W'(1)));
endmodule

// File: rtl/uart_txg_fifo.sv
// Holding queue: a circular buffer with push and pop.
// Assumes: a push when full is dropped even if a pop occurs in the same
// cycle; a pop when empty is ignored.
module uart_txg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rp];
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + AW'(1);
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R8: occupancy never exceeds the depth.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4: the shifter never takes a byte from an empty queue.
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/uart_txg_shift.sv
// Character shifter: loads a byte on a baud tick when allowed, then sends
// the start bit, 8 data bits LSB first and the stop bit, each held for
// OVS ticks.
// Assumes: `enable` gates loading only; a frame in flight always completes.
module uart_txg_shift #(
    parameter int OVS = 16,
    parameter int NB  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       avail,
    input  logic [7:0] data,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(NB);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(NB - 1);

    logic [SW-1:0] sub;
    logic [BW-1:0] bitn;
    logic [NB-1:0] frame;
    logic          bit_end, load;

    always_comb begin
        bit_end = busy && tick && (sub == SUB_LAST);
        load    = tick && enable && avail &&
                  (!busy || (bit_end && bitn == BIT_LAST));
        pop     = load;
    end

    // Load a new frame, or step through the current one on baud ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            txd   <= 1'b1;
            sub   <= '0;
            bitn  <= '0;
            frame <= '1;
        end else if (load) begin
            frame <= {1'b1, data, 1'b0};
            txd   <= 1'b0;
            busy  <= 1'b1;
            sub   <= '0;
            bitn  <= '0;
        end else if (busy && tick) begin
            if (sub == SUB_LAST) begin
                sub <= '0;
                if (bitn == BIT_LAST) begin
                    busy <= 1'b0;
                end else begin
                    bitn <= bitn + BW'(1);
                    txd  <= frame[bitn + BW'(1)];
                end
            end else begin
                sub <= sub + SW'(1);
            end
        end
    end

    // R3: the line is high whenever no frame is in flight.
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    // R6: inside a bit period the line does not move.
    a_r6_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(txd));
    // R5: with the gate shut and nothing in flight, no start bit appears.
    a_r5_no_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> txd);
endmodule

// File: rtl/uart_tx_gated.sv
// Top: register port, holding queue, baud generator and shifter.
// Assumes: writes take effect on the clock edge; reads are combinational.
module uart_tx_gated #(
    parameter int          DEPTH     = 16,
    parameter int          DIV_W     = 16,
    parameter logic [15:0] DIV_RESET = 16'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       txd,
    output logic       fifo_empty,
    output logic       tx_idle,
    output logic       overflow
);
    import uart_txg_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             ovf_q;
    logic             push, full, pop, tick, busy;
    logic [7:0]       head;

    always_comb push = wr_en && (wr_addr == ADDR_DATA);

    // Hold the divisor, the enable flag and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RESET);
            en_q  <= 1'b1;
            ovf_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_DIV_LO) div_q[7:0]  <= wr_data;
            if (wr_en && wr_addr == ADDR_DIV_HI) div_q[15:8] <= wr_data;
            if (wr_en && wr_addr == ADDR_CTRL)   en_q <= wr_data[EN_BIT];
            if (push && full)                    ovf_q <= 1'b1;
        end
    end

    // Register read mux; reserved control bits read 0.
    always_comb begin
        unique case (rd_addr)
            ADDR_DIV_LO: rd_data = div_q[7:0];
            ADDR_DIV_HI: rd_data = div_q[15:8];
            ADDR_CTRL:   rd_data = {en_q, 7'd0};
            default:     rd_data = 8'd0;
        endcase
    end

    uart_txg_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
        .dout(head), .empty(fifo_empty), .full(full)
    );

    uart_txg_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    uart_txg_shift #(.OVS(OVERSAMPLE), .NB(FRAME_LEN)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_q),
        .avail(!fifo_empty), .data(head), .pop(pop), .txd(txd), .busy(busy)
    );

    always_comb begin
        tx_idle  = fifo_empty && !busy;
        overflow = ovf_q;
    end

    // R8: once set, the overflow flag stays set until reset.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R10: an idle transmitter holds the line high.
    a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);
endmodule

// File: tb/sim_uart_tx_gated.sv
module sim_uart_tx_gated;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       txd, fifo_empty, tx_idle, overflow;

    int   total = 0;
    int   bad = 0;
    int   frames = 0;
    int   bdiv = 1;
    bit   mon_on = 1'b0;
    logic [7:0] expq [$];

    always #2.5 clk = ~clk;

    uart_tx_gated u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd),
        .fifo_empty(fifo_empty), .tx_idle(tx_idle), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // Driver: push a byte and record it as expected on the line.
    task automatic send(input logic [7:0] b);
        reg_wr(2'd0, b);
        expq.push_back(b);
    endtask

    // Monitor: decode frames at mid-bit and compare with the queue.
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on && prev && !txd) begin
                logic [7:0] got;
                repeat (8 * bdiv - 1) @(negedge clk);
                chk(txd == 1'b0, "R3 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (16 * bdiv) @(negedge clk);
                    got[i] = txd;
                end
                repeat (16 * bdiv) @(negedge clk);
                chk(txd == 1'b1, "R3 stop bit", txd, 1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", got, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(got == e, "R4 R3 byte order and value", got, e);
                end
                frames++;
            end
            prev = txd;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(fifo_empty == 1'b1, "R1 fifo_empty", fifo_empty, 1);
        chk(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        reg_rd(2'd3, r); chk(r == 8'h80, "R1 ctrl", r, 8'h80);
        reg_rd(2'd1, r); chk(r == 8'h01, "R1 div low", r, 8'h01);
        mon_on = 1'b1;

        // R2 register map
        reg_wr(2'd1, 8'd2); reg_wr(2'd2, 8'd0); bdiv = 2;
        reg_rd(2'd1, r); chk(r == 8'h02, "R2 div low", r, 8'h02);
        reg_rd(2'd2, r); chk(r == 8'h00, "R2 div high", r, 8'h00);
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd3, r); chk(r == 8'h80, "R2 reserved bits", r, 8'h80);
        reg_wr(2'd3, 8'h7F);
        reg_rd(2'd3, r); chk(r == 8'h00, "R2 enable clear", r, 8'h00);
        reg_rd(2'd0, r); chk(r == 8'h00, "R2 data read", r, 8'h00);

        // R5 gate closed: bytes stay queued
        send(8'h3C); send(8'hA5);
        repeat (400) @(negedge clk);
        chk(frames == 0, "R5 no frame", frames, 0);
        chk(txd == 1'b1, "R5 line high", txd, 1);
        chk(fifo_empty == 1'b0, "R5 R10 queue kept", fifo_empty, 0);
        chk(tx_idle == 1'b0, "R10 not idle", tx_idle, 0);

        // R7 reopen: start bit within D+1 clocks
        reg_wr(2'd3, 8'h80);
        n = 0;
        while (txd && n < 50) begin @(negedge clk); n++; end
        chk(n <= bdiv + 1, "R7 start latency", n, bdiv + 1);
        while (frames < 2) @(negedge clk);
        while (!tx_idle) @(negedge clk);
        chk(fifo_empty == 1'b1, "R10 drained", fifo_empty, 1);

        // R6 clear mid-frame: current frame completes, next waits
        send(8'h81); send(8'h7E);
        while (txd) @(negedge clk);
        repeat (40) @(negedge clk);
        reg_wr(2'd3, 8'h00);
        while (frames < 3) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(frames == 3, "R6 one frame only", frames, 3);
        chk(fifo_empty == 1'b0, "R6 R5 next kept", fifo_empty, 0);
        chk(txd == 1'b1, "R6 line high", txd, 1);
        reg_wr(2'd3, 8'h80);
        while (frames < 4) @(negedge clk);
        while (!tx_idle) @(negedge clk);

        // R8 overflow with gate shut
        reg_wr(2'd3, 8'h00);
        for (int i = 0; i < 16; i++) send(8'(i * 17 + 3));
        chk(overflow == 1'b0, "R8 full no overflow", overflow, 0);
        reg_wr(2'd0, 8'h55);
        chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
        // R9 divisor zero acts as one
        reg_wr(2'd1, 8'd0); bdiv = 1;
        reg_rd(2'd1, r); chk(r == 8'h00, "R9 div zero stored", r, 8'h00);
        reg_wr(2'd3, 8'h80);
        while (frames < 20) @(negedge clk);
        while (!tx_idle) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(frames == 20, "R8 R9 frame count", frames, 20);
        chk(expq.size() == 0, "R4 queue drained", expq.size(), 0);
        chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
        chk(tx_idle == 1'b1 && fifo_empty == 1'b1, "R10 final idle",
            {tx_idle, fifo_empty}, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule